// File: doc/BRIEF.md
# Systolic FIR Datapath with Travelling Control Words

This block is a linear chain of NW filter stages. Each stage holds one coefficient register, one signed 16x16 multiplier and one 32-bit adder. Stage 0 forms its product alone. Every later stage adds its own product to the partial sum coming from the stage before it. The last stage drives the result stream. One stream path carries both weights and samples. Entries move forward two registers per stage, while partial sums move one register per stage. This gives each stage its own element of the sliding sample window.

The block has no global control signal. Instead, a 3-bit control word is issued every cycle at stage 0 and registered from stage to stage, so stage s acts on the word issued s cycles earlier. Each stage decodes only its own copy. This lets consecutive words choose different operations: weight loading, pipeline fill, result computation or idle. Each word still applies to its own wavefront through the pipeline. A typical program loads NW weights, writing the coefficients on the last load. It then fills the window with NW-1 samples and issues one compute word per result.

Top module: `sysfir_top`

## Requirements
- R1: Asserting rst_ni clears every coefficient, partial sum, window and control register. While reset is held and after it is released, res_o is 0 and res_valid_o is 0. Compute words issued before any coefficient write produce 0.
- R2: The control word is coded as follows. ctl_i[1:0] selects the operation: 0 = idle, 1 = load weight, 2 = fill, 3 = compute. ctl_i[2] is the coefficient-write bit. The entry e[j] taken in for the word issued at clock edge j depends on the operation: a load takes wgt_i, fill and compute take smp_i, and idle takes 0.
- R3: Take a compute word issued at edge j. Its result is visible on res_o after edge j+NW-1. The result equals the sum over s = 0..NW-1 of W[s]*e[j-s]. Both operands are signed 16-bit values, and entries from before reset count as 0.
- R4: res_valid_o is 1 after edge j+NW-1 exactly when the word issued at edge j is a compute word. Load, fill and idle words are never flagged.
- R5: A word with the write bit, issued at edge j, sets W[s] = e[j-s] in every stage. As a result, NW loads presented in the order W[NW-1] first and W[0] last, with the write bit on the last load, install the coefficient vector. The issuing word itself still uses the old coefficients.
- R6: Words without the write bit leave every coefficient unchanged, including load words. Their entries only enter the window.
- R7: Partial sums wrap modulo 2^32 without saturation. For example, with NW=4, four products of (-32768)*(-32768) give 0.
- R8: Control is applied per stage. A coefficient write issued right behind compute words does not change the results of those earlier words. Arbitrary per-cycle mixes of operations each produce the result R3 gives.
- R9: An idle word puts a zero entry into the window and raises no valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_i | input | 3 | Control word for the current cycle |
| wgt_i | input | 16 | Weight stream, read by load words |
| smp_i | input | 16 | Sample stream, read by fill and compute words |
| res_o | output | 32 | Result stream from the last stage |
| res_valid_o | output | 1 | Marks res_o as a computed result |

## Verification
The hardest situation to reach is a coefficient write that arrives while older compute words are still in the later stages. In that case each stage must use a different coefficient generation, depending on its position. The stimulus creates this by issuing a write-load sequence straight after compute words, with no fill in between. It then keeps computing while the window still holds weight entries. A long sweep of random operations, with the write bit set on about one word in four, repeats this at every alignment. Extreme-valued phases drive the sums through the 2^32 wrap.

// File: rtl/sysfir_pkg.sv
package sysfir_pkg;
  localparam int CTL_W = 3;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LOAD = 2'd1,
    OP_FILL = 2'd2,
    OP_COMP = 2'd3
  } op_e;

  // op occupies bits [1:0], write bit is bit 2
  typedef struct packed {
    logic wr_coef;
    op_e  op;
  } ctl_t;
endpackage

// File: rtl/sysfir_src.sv
module sysfir_src
  import sysfir_pkg::*;
#(
  parameter int DW = 16
) (
  input  ctl_t          ctl_i,
  input  logic [DW-1:0] wgt_i,
  input  logic [DW-1:0] smp_i,
  output logic [DW-1:0] dat_o
);
  always_comb begin
    unique case (ctl_i.op)
      OP_LOAD:          dat_o = wgt_i;
      OP_FILL, OP_COMP: dat_o = smp_i;
      default:          dat_o = '0;
    endcase
  end
endmodule

// File: rtl/sysfir_dly.sv
module sysfir_dly #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else begin
      q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) q[i] <= q[i-1];
    end
  end

  assign q_o = q[DEPTH-1];
endmodule

// File: rtl/sysfir_stage.sv
module sysfir_stage
  import sysfir_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctl_t          ctl_i,
  input  logic [DW-1:0] dat_i,
  input  logic [AW-1:0] psum_i,
  output logic [AW-1:0] psum_o
);
  logic [DW-1:0]          coef_q;
  logic signed [2*DW-1:0] prod;

  assign prod = $signed(dat_i) * $signed(coef_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_q <= '0;
      psum_o <= '0;
    end else begin
      if (ctl_i.wr_coef) coef_q <= dat_i;
      psum_o <= psum_i + AW'(prod);  // wraps, no saturation
    end
  end
endmodule

// File: rtl/sysfir_top.sv
module sysfir_top
  import sysfir_pkg::*;
#(
  parameter int NW = 4,
  parameter int DW = 16,
  parameter int AW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic [DW-1:0]    wgt_i,
  input  logic [DW-1:0]    smp_i,
  output logic [AW-1:0]    res_o,
  output logic             res_valid_o
);
  // window entries advance two registers per stage, sums one
  localparam int SKEW = 2;

  logic [CTL_W-1:0] ctl_ch  [NW];
  logic [DW-1:0]    dat_ch  [NW];
  logic [AW-1:0]    psum_ch [NW+1];
  logic             vld_q;

  assign ctl_ch[0]  = ctl_i;
  assign psum_ch[0] = '0;

  sysfir_src #(.DW(DW)) u_src (
    .ctl_i (ctl_t'(ctl_ch[0])),
    .wgt_i (wgt_i),
    .smp_i (smp_i),
    .dat_o (dat_ch[0])
  );

  for (genvar s = 0; s < NW; s++) begin : g_st
    sysfir_stage #(.DW(DW), .AW(AW)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ctl_i  (ctl_t'(ctl_ch[s])),
      .dat_i  (dat_ch[s]),
      .psum_i (psum_ch[s]),
      .psum_o (psum_ch[s+1])
    );
    if (s < NW-1) begin : g_fwd
      sysfir_dly #(.W(DW), .DEPTH(SKEW)) u_dat (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (dat_ch[s]),
        .q_o   (dat_ch[s+1])
      );
      sysfir_dly #(.W(CTL_W), .DEPTH(1)) u_ctl (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (ctl_ch[s]),
        .q_o   (ctl_ch[s+1])
      );
    end
  end

  // valid travels with the last stage's word; op sits in bits [1:0]
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= (op_e'(ctl_ch[NW-1][1:0]) == OP_COMP);
  end

  assign res_o       = psum_ch[NW];
  assign res_valid_o = vld_q;
endmodule

module sysfir_chk
  import sysfir_pkg::*;
#(
  parameter int AW = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CTL_W-1:0] ctl_i,
  input logic [CTL_W-1:0] ctl_one,
  input logic [CTL_W-1:0] ctl_last,
  input logic             res_valid_o,
  input logic [AW-1:0]    res_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_rst_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!res_valid_o && res_o == '0));

  p_vld_after_comp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_last[1:0] == OP_COMP) |=> res_valid_o);

  p_vld_only_comp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && res_valid_o) |-> ($past(ctl_last[1:0]) == OP_COMP));

  p_ctl_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (ctl_one == $past(ctl_i)));
endmodule

bind sysfir_top sysfir_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_i       (ctl_i),
  .ctl_one     (ctl_ch[1]),
  .ctl_last    (ctl_ch[NW-1]),
  .res_valid_o (res_valid_o),
  .res_o       (res_o)
);

// File: tb/sysfir_top_tb.sv
`timescale 1ns/1ps
module sysfir_top_tb;
  localparam int NW   = 4;
  localparam int DW   = 16;
  localparam int AW   = 32;
  localparam int MAXN = 1024;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic [2:0]    ctl_i = '0;
  logic [DW-1:0] wgt_i = '0;
  logic [DW-1:0] smp_i = '0;
  logic [AW-1:0] res_o;
  logic          res_valid_o;

  sysfir_top #(.NW(NW), .DW(DW), .AW(AW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_i(ctl_i), .wgt_i(wgt_i),
    .smp_i(smp_i), .res_o(res_o), .res_valid_o(res_valid_o)
  );

  always #2.5 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic signed [DW-1:0] ent  [MAXN];
  logic signed [DW-1:0] wm   [NW];
  logic [AW-1:0]        xval [MAXN];
  bit                   xvld [MAXN];
  string                xtag [MAXN];
  int                   ncyc = 0;

  task automatic chk_word(input int j);
    checks++;
    if (res_valid_o !== xvld[j]) begin
      errors++;
      $display("FAIL R4 (%s) word %0d: res_valid_o=%b expected %b", xtag[j], j, res_valid_o, xvld[j]);
    end
    if (xvld[j]) begin
      checks++;
      if (res_o !== xval[j]) begin
        errors++;
        $display("FAIL R3 (%s) word %0d: res_o=%h expected %h", xtag[j], j, res_o, xval[j]);
      end
    end
  endtask

  // op: 0 idle, 1 load, 2 fill, 3 compute; called at a falling edge
  task automatic issue(input logic [1:0] op, input bit wr, input logic [15:0] wv,
                       input logic [15:0] sv, input string tag);
    int acc;
    ctl_i = {wr, op};
    wgt_i = wv;
    smp_i = sv;
    ent[ncyc] = (op == 2'd1) ? wv : ((op >= 2'd2) ? sv : 16'd0);
    acc = 0;
    for (int s = 0; s < NW; s++)
      if (ncyc >= s) acc = acc + int'(wm[s]) * int'(ent[ncyc-s]);
    xval[ncyc] = acc;
    xvld[ncyc] = (op == 2'd3);
    xtag[ncyc] = tag;
    if (wr)
      for (int s = 0; s < NW; s++) wm[s] = (ncyc >= s) ? ent[ncyc-s] : 16'sd0;
    ncyc++;
    @(posedge clk_i);
    @(negedge clk_i);
    if (ncyc >= NW) chk_word(ncyc - NW);
  endtask

  task automatic load_w(input logic [15:0] w0, w1, w2, w3, input string tag);
    issue(2'd1, 1'b0, w3, 16'h0, tag);
    issue(2'd1, 1'b0, w2, 16'h0, tag);
    issue(2'd1, 1'b0, w1, 16'h0, tag);
    issue(2'd1, 1'b1, w0, 16'h0, tag);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    for (int s = 0; s < NW; s++) wm[s] = '0;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    checks++;
    if (res_o !== '0 || res_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: res_o=%h vld=%b expected 0 0", res_o, res_valid_o);
    end
    rst_ni = 1'b1;
    checks++;
    if (res_o !== '0 || res_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 after release: res_o=%h vld=%b expected 0 0", res_o, res_valid_o);
    end

    // R1: coefficients are zero after reset
    for (int i = 0; i < 6; i++) issue(2'd3, 1'b0, 16'h0, 16'(i * 1234 + 7), "R1");

    // R5: install W = {3,-5,7,2}, fill, then an impulse
    load_w(16'd3, -16'sd5, 16'd7, 16'd2, "R5");
    for (int i = 0; i < NW-1; i++) issue(2'd2, 1'b0, 16'h0, 16'h0, "R5");
    issue(2'd3, 1'b0, 16'h0, 16'd1, "R5");
    for (int i = 0; i < NW+2; i++) issue(2'd3, 1'b0, 16'h0, 16'h0, "R5");
    for (int i = 0; i < 8; i++) issue(2'd3, 1'b0, 16'hAAAA, 16'(i * 301 - 900), "R5");

    // R6: loads without write bit only feed the window
    for (int i = 0; i < NW; i++) issue(2'd1, 1'b0, 16'(16'h7000 + i), 16'h0, "R6");
    for (int i = 0; i < 6; i++) issue(2'd3, 1'b0, 16'h1111, 16'(i + 1), "R6");

    // R9: idle bubbles between computes
    for (int i = 0; i < 8; i++) begin
      issue(2'd3, 1'b0, 16'h0, 16'(100 + i), "R9");
      issue(2'd0, 1'b0, 16'h5555, 16'h5555, "R9");
    end

    // R8: write right behind computes, alternating fill and compute
    for (int i = 0; i < 3; i++) issue(2'd3, 1'b0, 16'h0, 16'(40 + i), "R8");
    load_w(-16'sd9, 16'd4, 16'd11, -16'sd1, "R8");
    for (int i = 0; i < 10; i++) issue((i % 2) ? 2'd2 : 2'd3, 1'b0, 16'h0, 16'(i * 77 - 333), "R8");

    // R7: wrap of full-scale sums
    load_w(16'h8000, 16'h8000, 16'h8000, 16'h8000, "R7");
    for (int i = 0; i < NW+2; i++) issue(2'd3, 1'b0, 16'h0, 16'h8000, "R7");
    load_w(16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, "R7");
    for (int i = 0; i < NW+2; i++) issue(2'd3, 1'b0, 16'h0, 16'h8000, "R7");

    // R2/R8: random sweep of all encodings
    for (int i = 0; i < 400; i++)
      issue(2'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0),
            16'($urandom), 16'($urandom), "R2");

    for (int i = 0; i < NW; i++) issue(2'd0, 1'b0, 16'h0, 16'h0, "R9");
    done = 1;
    summary();
  end
endmodule